// File: doc/BRIEF.md
# Jittered Oscillator with Foldback

A digitally controlled switching oscillator for an off-line power stage. The block counts a fast system clock to produce one switching cycle after another. It raises a one-clock pulse at the start of every cycle and a maximum-duty-cycle window that opens with the pulse and closes at a fixed fraction of the cycle. The length of the current cycle, in system clocks, is also shown on an output.

Two effects shape the cycle length together. The first is a slow symmetric triangular dither of about ±5 % of the frequency, which spreads conducted emissions. The dither is stepped once per switching cycle, so one full up/down sweep takes one millisecond at the nominal rate. The second is a linear frequency foldback driven by an unsigned feedback voltage code in millivolts. Above the regulation point the nominal frequency is used. Below it the frequency falls in a straight line to 48 % of nominal, and it stays at 48 % for every lower code.

The next cycle length is computed by a serial divider that starts at each cycle start and finishes well before the cycle ends. Each cycle therefore always runs to its programmed length and is never cut short.

Top module: `jit_fold_osc`

## Requirements
- R1: While reset is low, `cyc_start_o` and `dcmax_o` are low and `period_o` equals NOM = floor(SYS_CLK_HZ/FSW_HZ). The first start pulse appears in the first clock after reset is released, and that first cycle lasts NOM clocks.
- R2: `cyc_start_o` is high for exactly one clock per cycle. The number of clocks from one start pulse to the next equals the value `period_o` held during that cycle, and `period_o` changes only in a start-pulse clock.
- R3: Let the feedback code be present during the start-pulse clock of cycle n, let F be its foldback factor and D the dither term. The length of cycle n+1 is then floor(NOM·890000·1000·H / (F·D)), where H = floor(FSW_HZ/DITH_RATE_HZ/2).
- R4: For a feedback code of 1690 or more, F = 890000, which is full nominal frequency.
- R5: For a feedback code c with 800 < c < 1690, F = 427200 + 520·(c − 800), which is linear between 48 % and 100 %.
- R6: For a feedback code of 800 or less, F = 427200, a clamp at 48 % of nominal.
- R7: The dither term is D = 1000·H + (2k − H)·DITH_PM. The computation made at the start of cycle n (counting from 0 after reset) uses k = m if m ≤ H, and k = 2H − m otherwise, where m = n mod 2H.
- R8: A change of the feedback code outside the start-pulse clock does not affect the length of the current cycle or of the next one.
- R9: `dcmax_o` is high from the start-pulse clock for floor(P·DC_FRAC/256) clocks, where P is the current cycle length, and then stays low until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| fb_mv_i | input | FB_W | Feedback voltage code in millivolts, unsigned |
| cyc_start_o | output | 1 | One-clock pulse at the start of each switching cycle |
| dcmax_o | output | 1 | Maximum-duty-cycle window |
| period_o | output | PER_W | Length of the current cycle in system clocks |

## Verification
The feedback code seen in the start-pulse clock of cycle n is reflected on `period_o` only in the start-pulse clock of cycle n+1. That cycle's true length can be measured only at the start of cycle n+2, and its duty window count becomes complete at the same point. The bench samples every output just after the falling clock edge. A monitor counts clocks between start pulses, and each vector waits for two more start pulses so that each result is compared in the cycle where it is due. Mid-cycle feedback changes are applied a few clocks after the sampled start pulse, so their lack of effect shows in that same comparison.

// File: rtl/jfo_pkg.sv
package jfo_pkg;
  // Foldback factor scale: FAC_FULL means 100 % of nominal frequency.
  localparam int unsigned FB_FULL_MV  = 1690;
  localparam int unsigned FB_FLOOR_MV = 800;
  localparam int unsigned FAC_SLOPE   = 520;
  localparam int unsigned FAC_FLOOR   = 427200;
  localparam int unsigned FAC_FULL    = 890000;
  localparam int unsigned FAC_W       = 20;
endpackage

// File: rtl/jfo_foldback.sv
module jfo_foldback
  import jfo_pkg::*;
#(
  parameter int unsigned FB_W = 12
) (
  input  logic [FB_W-1:0]  fb_mv_i,
  output logic [FAC_W-1:0] fac_o
);

  logic [FB_W-1:0] over_floor;

  always_comb begin
    over_floor = fb_mv_i - FB_W'(FB_FLOOR_MV);
    if (fb_mv_i >= FB_W'(FB_FULL_MV)) begin
      fac_o = FAC_W'(FAC_FULL);
    end else if (fb_mv_i <= FB_W'(FB_FLOOR_MV)) begin
      fac_o = FAC_W'(FAC_FLOOR);
    end else begin
      fac_o = FAC_W'(FAC_FLOOR) + FAC_W'(over_floor) * FAC_W'(FAC_SLOPE);
    end
  end

endmodule

// File: rtl/jfo_tri_dither.sv
module jfo_tri_dither #(
  parameter int unsigned HALF    = 33,
  parameter int unsigned DEV_PM  = 50,
  parameter int unsigned D_W     = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_i,
  output logic [D_W-1:0] dith_o
);

  localparam int unsigned K_W    = $clog2(HALF + 1);
  localparam int unsigned D_BASE = HALF * (1000 - DEV_PM);

  logic [K_W-1:0] k_q, k_d;
  logic           up_q, up_d;

  always_comb begin
    k_d  = k_q;
    up_d = up_q;
    if (step_i) begin
      if (up_q) begin
        k_d = k_q + 1'b1;
        if (k_q == K_W'(HALF - 1)) up_d = 1'b0;
      end else begin
        k_d = k_q - 1'b1;
        if (k_q == K_W'(1)) up_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q  <= '0;
      up_q <= 1'b1;
    end else begin
      k_q  <= k_d;
      up_q <= up_d;
    end
  end

  assign dith_o = D_W'(D_BASE) + D_W'(2 * DEV_PM) * D_W'(k_q);

endmodule

// File: rtl/jfo_serdiv.sv
module jfo_serdiv #(
  parameter longint unsigned DIVIDEND = 64'd1000,
  parameter int unsigned     N_W      = 10,
  parameter int unsigned     DVS_W    = 8,
  parameter int unsigned     Q_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic [Q_W-1:0]   quot_o,
  output logic             done_o
);

  localparam int unsigned C_W = $clog2(N_W + 1);

  logic [DVS_W-1:0] rem_q, rem_d;
  logic [DVS_W-1:0] dvs_q, dvs_d;
  logic [N_W-1:0]   quo_q, quo_d;
  logic [C_W-1:0]   cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [DVS_W:0]   trial;
  logic             fits;

  always_comb begin
    trial  = {rem_q, quo_q[N_W-1]};
    fits   = trial >= {1'b0, dvs_q};
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start_i) begin
      rem_d  = '0;
      dvs_d  = divisor_i;
      quo_d  = N_W'(DIVIDEND);
      cnt_d  = C_W'(N_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = fits ? DVS_W'(trial - {1'b0, dvs_q}) : trial[DVS_W-1:0];
      quo_d = {quo_q[N_W-2:0], fits};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == C_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign quot_o = quo_q[Q_W-1:0];
  assign done_o = done_q;

endmodule

// File: rtl/jit_fold_osc.sv
module jit_fold_osc
  import jfo_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ   = 125_000_000,
  parameter int unsigned FSW_HZ       = 66_000,
  parameter int unsigned DITH_RATE_HZ = 1000,
  parameter int unsigned DITH_PM      = 50,
  parameter int unsigned DC_FRAC      = 166,
  parameter int unsigned FB_W         = 12,
  localparam int unsigned NOM_PER     = SYS_CLK_HZ / FSW_HZ,
  localparam int unsigned PER_W       = $clog2(NOM_PER * 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FB_W-1:0]  fb_mv_i,
  output logic             cyc_start_o,
  output logic             dcmax_o,
  output logic [PER_W-1:0] period_o
);

  localparam int unsigned SWEEP = FSW_HZ / DITH_RATE_HZ;
  localparam int unsigned HALF  = (SWEEP / 2 < 1) ? 1 : SWEEP / 2;
  localparam int unsigned D_W   = $clog2(HALF * (1000 + DITH_PM) + 1);
  localparam int unsigned DVS_W = FAC_W + D_W;
  localparam longint unsigned DIVIDEND =
    64'(NOM_PER) * 64'(FAC_FULL) * 64'd1000 * 64'(HALF);
  localparam int unsigned N_W   = $clog2(DIVIDEND + 1);

  logic             live_q, live_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] nxt_q, nxt_d;
  logic             start_w, wrap_w;
  logic [FAC_W-1:0] fac;
  logic [D_W-1:0]   dith;
  logic [DVS_W-1:0] divisor;
  logic [PER_W-1:0] quot;
  logic             div_done;
  logic [PER_W+7:0] dc_prod;
  logic [PER_W-1:0] dc_len;

  jfo_foldback #(.FB_W(FB_W)) u_fold (
    .fb_mv_i (fb_mv_i),
    .fac_o   (fac)
  );

  jfo_tri_dither #(.HALF(HALF), .DEV_PM(DITH_PM), .D_W(D_W)) u_dith (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (start_w),
    .dith_o (dith)
  );

  assign divisor = DVS_W'(fac) * DVS_W'(dith);

  jfo_serdiv #(.DIVIDEND(DIVIDEND), .N_W(N_W), .DVS_W(DVS_W), .Q_W(PER_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_w),
    .divisor_i (divisor),
    .quot_o    (quot),
    .done_o    (div_done)
  );

  assign start_w = live_q && (cnt_q == '0);
  assign wrap_w  = live_q && (cnt_q == per_q - 1'b1);

  always_comb begin
    live_d = 1'b1;
    cnt_d  = cnt_q;
    per_d  = per_q;
    nxt_d  = nxt_q;
    if (live_q) begin
      if (wrap_w) begin
        cnt_d = '0;
        per_d = nxt_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (div_done) nxt_d = quot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
      per_q  <= PER_W'(NOM_PER);
      nxt_q  <= PER_W'(NOM_PER);
    end else begin
      live_q <= live_d;
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      nxt_q  <= nxt_d;
    end
  end

  assign dc_prod     = {8'b0, per_q} * (PER_W + 8)'(DC_FRAC);
  assign dc_len      = dc_prod[PER_W+7:8];
  assign cyc_start_o = start_w;
  assign dcmax_o     = live_q && (cnt_q < dc_len);
  assign period_o    = per_q;

endmodule

// File: rtl/jfo_checker.sv
module jfo_checker #(
  parameter int unsigned PER_W   = 8,
  parameter int unsigned NOM_PER = 80
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start_o,
  input logic             dcmax_o,
  input logic [PER_W-1:0] period_o
);

  localparam int unsigned P_LO = NOM_PER * 9 / 10;
  localparam int unsigned P_HI = NOM_PER * 23 / 10;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!cyc_start_o && !dcmax_o)); // R1

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_o |=> !cyc_start_o); // R2

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start_o |-> $stable(period_o)); // R2

  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (period_o >= PER_W'(P_LO)) && (period_o <= PER_W'(P_HI))); // R3

  AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_o |-> dcmax_o); // R9

  AST_WINDOW_STAYS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!dcmax_o && !cyc_start_o) |=> (!dcmax_o || cyc_start_o)); // R9

endmodule

bind jit_fold_osc jfo_checker #(.PER_W(PER_W), .NOM_PER(NOM_PER)) u_jfo_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_start_o (cyc_start_o),
  .dcmax_o     (dcmax_o),
  .period_o    (period_o)
);

// File: tb/test_jit_fold_osc.sv
`timescale 1ns/1ps
module test_jit_fold_osc;

  localparam int NOM = 80;
  localparam int H   = 50;
  localparam int DEV = 50;
  localparam int DCF = 166;
  localparam int PW  = 8;

  typedef struct packed {
    int fb;
    int fb_mid;
    int fac;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2000,    0, 890000},  // R4, late drop to 0 (R8)
    '{1690,  900, 890000},  // R4 boundary
    '{1689, 2000, 889480},  // R5 just below
    '{1245, 1690, 658600},  // R5 middle
    '{1000, 4095, 531200},  // R5
    '{ 801, 1690, 427720},  // R5 just above floor
    '{ 800, 2000, 427200},  // R6 boundary
    '{ 300, 1690, 427200},  // R6
    '{   0, 2000, 427200},  // R6 zero
    '{4095,  800, 890000}   // R4 full scale
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [11:0]   fb_mv;
  logic          cyc_start;
  logic          dcmax;
  logic [PW-1:0] period;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  int cyc_idx = -1;
  int run_len = 0, dc_cnt = 0, last_len = 0, last_dc = 0, cur_per = 0;
  bit stab_bad = 0;

  always #4 clk = ~clk;

  jit_fold_osc #(
    .SYS_CLK_HZ (8_000_000),
    .FSW_HZ     (100_000)
  ) i_jit_fold_osc (
    .clk         (clk),
    .rst_n       (rst_n),
    .fb_mv_i     (fb_mv),
    .cyc_start_o (cyc_start),
    .dcmax_o     (dcmax),
    .period_o    (period)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc_idx = -1; run_len = 0; dc_cnt = 0; cur_per = 0;
    end else if (cyc_start) begin
      last_len = run_len;
      last_dc  = dc_cnt;
      run_len  = 1;
      dc_cnt   = dcmax ? 1 : 0;
      cyc_idx++;
      cur_per  = int'(period);
    end else begin
      run_len++;
      if (dcmax) dc_cnt++;
      if (cyc_idx >= 0 && int'(period) != cur_per) stab_bad = 1;
    end
  end

  function automatic int tri_k(int n);
    int m = n % (2 * H);
    return (m <= H) ? m : 2 * H - m;
  endfunction

  function automatic longint exp_per(longint fac, int k);
    longint num = longint'(NOM) * 890000 * 1000 * H;
    longint den = fac * (1000 * H + (2 * k - H) * DEV);
    return num / den;
  endfunction

  function automatic int exp_dc(int p);
    return (p * DCF) >>> 8;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_start();
    do tick(); while (!cyc_start);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    longint prev_exp;
    rst_n = 1'b0;
    fb_mv = 12'd2000;
    repeat (5) tick();
    chk("R1 start low in reset", cyc_start, 0);
    chk("R1 window low in reset", dcmax, 0);
    chk("R1 period in reset", period, NOM);
    rst_n = 1'b1;
    tick();
    chk("R1 first start pulse", cyc_start, 1);
    chk("R1 first period", period, NOM);

    // R7: full triangular sweep at full frequency, plus turnaround
    prev_exp = NOM;
    for (int i = 1; i <= 110; i++) begin
      wait_start();
      chk((i == 1) ? "R1 first cycle length" : "R2 cycle length", last_len, prev_exp);
      prev_exp = exp_per(890000, tri_k(cyc_idx - 1));
      chk("R7 dithered period", period, prev_exp);
    end

    // Table of feedback vectors: R3 to R6, R8, R9
    for (int v = 0; v < NV; v++) begin
      int  n;
      longint p_n, p_n1;
      string tag;
      tag = (VEC[v].fb >= 1690) ? "R3 R4 period" :
            (VEC[v].fb <= 800)  ? "R3 R6 period" : "R3 R5 period";
      wait_start();
      fb_mv = 12'(VEC[v].fb);
      wait_start();
      n   = cyc_idx;
      p_n = exp_per(VEC[v].fac, tri_k(n - 1));
      repeat (3) tick();
      fb_mv = 12'(VEC[v].fb_mid);
      wait_start();
      p_n1 = exp_per(VEC[v].fac, tri_k(n));
      chk(tag, period, p_n1);
      chk("R8 current length unaffected", last_len, p_n);
      wait_start();
      chk("R8 next length unaffected", last_len, p_n1);
      chk("R9 window length", last_dc, exp_dc(int'(p_n1)));
    end

    // Reset in the middle of a cycle
    wait_start();
    repeat (10) tick();
    rst_n = 1'b0;
    #1;
    chk("R1 start low after mid reset", cyc_start, 0);
    chk("R1 window low after mid reset", dcmax, 0);
    chk("R1 period after mid reset", period, NOM);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 start after mid reset", cyc_start, 1);
    wait_start();
    chk("R1 length after mid reset", last_len, NOM);
    chk("R9 window after mid reset", last_dc, exp_dc(NOM));

    chk("R2 period stable within cycles", stab_bad, 0);
    summary();
  end

endmodule